// File: doc/BRIEF.md
# Shared Packet Slot Pool Manager

This block tracks a small pool of fixed-size packet slots that transmit and receive traffic share. It holds a bitmap of the slots in use, a transmit queue, a completion queue for slots already sent, and a receive queue. It also holds the interrupt status byte and its mask. A host drives it through one write port. A select field steers each write to the command decoder, the acknowledge logic or the mask register. A receive engine asks for slots through a request line. A transmit engine drains queued slots through a valid/ready handshake.

Transmit allocation can be deferred. When a host asks for a transmit slot while the pool is full, the allocation result reads 0x80. Every later release of a slot retries the allocation in the same cycle, so the host only has to watch the allocation-done status bit. Only one event is taken per clock. A host write has priority over a receive request, and a receive request has priority over a transmit hand-off.

Top module: `pool_mgr`

## Requirements
- R1: The pool has NUM_SLOTS slots (default 4). Every allocation grants the lowest-numbered free slot. `alloc_result` reads 0x80 while no transmit slot could be granted.
- R2: A write with `wr_sel`=0 is a command, and the opcode sits in `wr_data[7:5]`. Opcode 0, and `wr_sel`=3, change nothing.
- R3: Opcode 1 asks for a transmit slot. If a slot is free, `alloc_result` becomes its index and status bit 3 is set. If none is free, `alloc_result` becomes 0x80 and status bit 3 is cleared.
- R4: When a slot is freed by opcode 5, opcode 4 or auto-release while `alloc_result` is 0x80, the transmit allocation is retried in that same cycle.
- R5: The status bits are: bit0 receive, bit1 transmit done, bit2 transmit queue empty, bit3 allocation done, bit4 receive overrun, bit5 PHY event, bit6 early receive, bit7 MII. A write with `wr_sel`=2 loads the mask. `irq` is high when any status bit and its mask bit are both 1.
- R6: Bit 2 becomes set whenever the transmit queue is empty, and bit 1 becomes set whenever the completion queue holds an entry. Both bits stay set until they are acknowledged.
- R7: A write with `wr_sel`=1 clears the status bits in `wr_data & 0xD6`. If `wr_data` bit 1 is set, the head of the completion queue is also removed.
- R8: A receive request with no host write and a free slot raises `rx_grant` in the same cycle. The lowest free slot is shown on `rx_slot`, appended to the receive queue, and status bit 0 is set. With no free slot, `rx_grant` stays low.
- R9: Opcode 3 drops the receive head, and opcode 4 drops it and frees its slot. After either, status bit 0 is set only if entries remain.
- R10: Opcode 6 appends `pkt_num` to the transmit queue. Opcode 5 frees slot `pkt_num`. Opcode 7 empties the transmit and completion queues. Opcode 2 empties the bitmap and all queues and sets `alloc_result` to 0.
- R11: `tx_valid` is high only while `tx_en` is set and the transmit queue is not empty. It offers slots in queue order, and each accepted hand-off removes one slot. On acceptance, with `auto_release` set the slot is freed; otherwise it is appended to the completion queue if there is room.
- R12: `done_head` and `rx_head` read 0x80 while their queue is empty.
- R13: After reset, the bitmap and queues are empty, the status is 0x04, the mask is 0 and `alloc_result` is 0. `used_count` counts busy slots, and `total_slots` equals NUM_SLOTS.
- R14: Only one event is taken per cycle. A host write blocks `rx_grant` and `tx_valid`, and a receive request blocks `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | 0 command, 1 acknowledge, 2 mask, 3 none |
| wr_data | input | 8 | Host write data |
| pkt_num | input | IDX_W | Slot named by opcodes 5 and 6 |
| tx_en | input | 1 | Transmit enable |
| auto_release | input | 1 | Free slots once sent |
| rx_req | input | 1 | Receive slot request |
| rx_grant | output | 1 | Receive request granted this cycle |
| rx_slot | output | IDX_W | Slot granted to receive |
| tx_valid | output | 1 | A queued slot is offered for sending |
| tx_slot | output | IDX_W | Slot offered for sending |
| tx_ready | input | 1 | Transmit engine takes the offered slot |
| alloc_result | output | 8 | Transmit allocation result, or 0x80 |
| done_head | output | 8 | Completion queue head, or 0x80 |
| rx_head | output | 8 | Receive queue head, or 0x80 |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |
| used_count | output | CNT_W | Number of busy slots |
| total_slots | output | CNT_W | Pool size |

## Verification
`rx_grant`, `rx_slot`, `tx_valid` and `tx_slot` are combinational, so they are due in the same cycle as the request or the queue state that drives them. The bench samples them one nanosecond after it drives the inputs on a falling edge. Every other result is registered and appears after the next rising edge. Each host write, receive request or ready pulse is held for exactly one rising edge, and the checks are made at the following falling edge. Chains within a single cycle are checked at that same falling edge: an auto-release that retries a pending allocation, and an acknowledge that pops the completion queue and then sets bit 1 again.

// File: rtl/pool_mgr_pkg.sv
package pool_mgr_pkg;

   localparam logic [7:0] SLOT_NONE     = 8'h80;
   localparam logic [7:0] ACK_CLEARABLE = 8'hD6;

   localparam int IB_RX      = 0;
   localparam int IB_TXDONE  = 1;
   localparam int IB_TXEMPTY = 2;
   localparam int IB_ALLOC   = 3;

   typedef enum logic [2:0] {
      OP_NOP        = 3'd0,
      OP_TX_ALLOC   = 3'd1,
      OP_POOL_RESET = 3'd2,
      OP_RX_DROP    = 3'd3,
      OP_RX_FREE    = 3'd4,
      OP_FREE_SLOT  = 3'd5,
      OP_TX_QUEUE   = 3'd6,
      OP_TX_FLUSH   = 3'd7
   } pool_op_e;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_ACK  = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } wr_sel_e;

endpackage

// File: rtl/free_finder.sv
module free_finder #(
   parameter int SLOTS = 4,
   parameter int IDX_W = 2
) (
   input  logic [SLOTS-1:0] busy,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   // Scan downward so the lowest free slot is the last one to win.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            found = 1'b1;
            idx   = i[IDX_W-1:0];
         end
      end
   end

endmodule

// File: rtl/slot_queue.sv
module slot_queue #(
   parameter  int DEPTH = 4,
   parameter  int W     = 2,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_q, wr_q, rd_inc, wr_inc;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign do_push = push && (cnt_q != CW'(DEPTH));
   assign do_pop  = pop && (cnt_q != '0);

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign rd_inc = rd_q + 1'b1;
         assign wr_inc = wr_q + 1'b1;
      end else begin : g_wrap
         assign rd_inc = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_inc = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_inc;
         if (do_pop)  rd_q <= rd_inc;
         cnt_q <= cnt_q + {{(CW-1){1'b0}}, do_push} - {{(CW-1){1'b0}}, do_pop};
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_q] <= din;
   end

   assign head  = mem[rd_q];
   assign count = cnt_q;

endmodule

// File: rtl/pool_mgr.sv
module pool_mgr
   import pool_mgr_pkg::*;
#(
   parameter  int NUM_SLOTS = 4,
   localparam int IDX_W     = $clog2(NUM_SLOTS),
   localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] pkt_num,
   input  logic             tx_en,
   input  logic             auto_release,
   input  logic             rx_req,
   output logic             rx_grant,
   output logic [IDX_W-1:0] rx_slot,
   output logic             tx_valid,
   output logic [IDX_W-1:0] tx_slot,
   input  logic             tx_ready,
   output logic [7:0]       alloc_result,
   output logic [7:0]       done_head,
   output logic [7:0]       rx_head,
   output logic [7:0]       int_status,
   output logic [7:0]       int_mask,
   output logic             irq,
   output logic [CNT_W-1:0] used_count,
   output logic [CNT_W-1:0] total_slots
);

   localparam logic [CNT_W-1:0] CAP     = CNT_W'(NUM_SLOTS);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [7:0]       ST_RST  = 8'(1 << IB_TXEMPTY);

   initial assert (NUM_SLOTS >= 2 && NUM_SLOTS <= 127 && (1 << IDX_W) == NUM_SLOTS)
      else $error("pool_mgr: NUM_SLOTS must be a power of two in 2..64");

   function automatic logic [7:0] widen(input logic [IDX_W-1:0] v);
      return {{(8-IDX_W){1'b0}}, v};
   endfunction

   function automatic logic [CNT_W-1:0] cnt_after(input logic [CNT_W-1:0] c,
                                                  input logic clr, push, pop);
      if (clr) return '0;
      return c + {{(CNT_W-1){1'b0}}, push} - {{(CNT_W-1){1'b0}}, pop};
   endfunction

   logic [NUM_SLOTS-1:0] bm_q, bm_d, busy_view;
   logic [7:0]           res_q, res_d, st_q, st_d, mask_q, mask_d;
   logic                 find_ok;
   logic [IDX_W-1:0]     find_idx;
   logic                 free_en, take;
   logic [IDX_W-1:0]     free_idx;
   logic                 txq_push, txq_pop, txq_clr;
   logic                 dq_push, dq_pop, dq_clr;
   logic                 rxq_push, rxq_pop, rxq_clr;
   logic [IDX_W-1:0]     txq_head, dq_head, rxq_head;
   logic [CNT_W-1:0]     txq_cnt, dq_cnt, rxq_cnt;
   logic                 tx_fire;
   pool_op_e             op;

   assign op = pool_op_e'(wr_data[7:5]);

   // one event per cycle: host write, then receive request, then transmit hand-off
   assign tx_valid = tx_en && (txq_cnt != '0) && !wr_en && !rx_req;
   assign tx_slot  = txq_head;
   assign tx_fire  = tx_valid && tx_ready;

   // which slot is released this cycle (needed before the free search)
   always_comb begin
      free_en  = 1'b0;
      free_idx = pkt_num;
      if (wr_en) begin
         if (wr_sel == SEL_CMD && op == OP_FREE_SLOT) begin
            free_en = 1'b1;
         end else if (wr_sel == SEL_CMD && op == OP_RX_FREE && rxq_cnt != '0) begin
            free_en  = 1'b1;
            free_idx = rxq_head;
         end
      end else if (tx_fire && auto_release) begin
         free_en  = 1'b1;
         free_idx = txq_head;
      end
   end

   always_comb begin
      busy_view = bm_q;
      if (free_en) busy_view[free_idx] = 1'b0;
   end

   free_finder #(.SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_find (
      .busy  (busy_view),
      .found (find_ok),
      .idx   (find_idx)
   );

   assign rx_grant = rx_req && !wr_en && find_ok && (rxq_cnt != CAP);
   assign rx_slot  = find_idx;

   always_comb begin
      take = 1'b0;
      res_d = res_q;
      st_d = st_q;
      mask_d = mask_q;
      txq_push = 1'b0; txq_pop = 1'b0; txq_clr = 1'b0;
      dq_push  = 1'b0; dq_pop  = 1'b0; dq_clr  = 1'b0;
      rxq_push = 1'b0; rxq_pop = 1'b0; rxq_clr = 1'b0;
      if (wr_en) begin
         case (wr_sel)
            SEL_CMD: begin
               case (op)
                  OP_TX_ALLOC: begin
                     res_d = SLOT_NONE;
                     st_d[IB_ALLOC] = 1'b0;
                     if (find_ok) begin
                        take = 1'b1;
                        res_d = widen(find_idx);
                        st_d[IB_ALLOC] = 1'b1;
                     end
                  end
                  OP_POOL_RESET: begin
                     txq_clr = 1'b1; dq_clr = 1'b1; rxq_clr = 1'b1;
                     res_d = '0;
                  end
                  OP_RX_DROP, OP_RX_FREE: begin
                     rxq_pop = (rxq_cnt != '0);
                     st_d[IB_RX] = (rxq_cnt > CNT_ONE);
                  end
                  OP_TX_QUEUE: txq_push = (txq_cnt != CAP);
                  OP_TX_FLUSH: begin
                     txq_clr = 1'b1; dq_clr = 1'b1;
                  end
                  default: ;
               endcase
            end
            SEL_ACK: begin
               st_d   = st_q & ~(wr_data & ACK_CLEARABLE);
               dq_pop = wr_data[IB_TXDONE] && (dq_cnt != '0);
            end
            SEL_MASK: mask_d = wr_data;
            default: ;
         endcase
      end else if (rx_grant) begin
         take = 1'b1;
         rxq_push = 1'b1;
         st_d[IB_RX] = 1'b1;
      end else if (tx_fire) begin
         txq_pop = 1'b1;
         if (!auto_release) dq_push = (dq_cnt != CAP);
      end
      // deferred transmit allocation retried on any release
      if (free_en && res_q == SLOT_NONE && find_ok) begin
         take = 1'b1;
         res_d = widen(find_idx);
         st_d[IB_ALLOC] = 1'b1;
      end
      if (cnt_after(txq_cnt, txq_clr, txq_push, txq_pop) == '0) st_d[IB_TXEMPTY] = 1'b1;
      if (cnt_after(dq_cnt, dq_clr, dq_push, dq_pop) != '0)     st_d[IB_TXDONE]  = 1'b1;
      bm_d = busy_view;
      if (take) bm_d[find_idx] = 1'b1;
      if (wr_en && wr_sel == SEL_CMD && op == OP_POOL_RESET) bm_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bm_q   <= '0;
         res_q  <= '0;
         st_q   <= ST_RST;
         mask_q <= '0;
      end else begin
         bm_q   <= bm_d;
         res_q  <= res_d;
         st_q   <= st_d;
         mask_q <= mask_d;
      end
   end

   slot_queue #(.DEPTH(NUM_SLOTS), .W(IDX_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(txq_clr), .push(txq_push), .din(pkt_num),
      .pop(txq_pop), .head(txq_head), .count(txq_cnt)
   );

   slot_queue #(.DEPTH(NUM_SLOTS), .W(IDX_W)) u_doneq (
      .clk(clk), .rst_n(rst_n), .clr(dq_clr), .push(dq_push), .din(txq_head),
      .pop(dq_pop), .head(dq_head), .count(dq_cnt)
   );

   slot_queue #(.DEPTH(NUM_SLOTS), .W(IDX_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rxq_clr), .push(rxq_push), .din(find_idx),
      .pop(rxq_pop), .head(rxq_head), .count(rxq_cnt)
   );

   always_comb begin
      used_count = '0;
      for (int i = 0; i < NUM_SLOTS; i++) used_count = used_count + {{(CNT_W-1){1'b0}}, bm_q[i]};
   end

   assign total_slots  = CAP;
   assign alloc_result = res_q;
   assign done_head    = (dq_cnt  == '0) ? SLOT_NONE : widen(dq_head);
   assign rx_head      = (rxq_cnt == '0) ? SLOT_NONE : widen(rxq_head);
   assign int_status   = st_q;
   assign int_mask     = mask_q;
   assign irq          = |(st_q & mask_q);

endmodule

// File: rtl/pool_mgr_chk.sv
module pool_mgr_chk #(
   parameter  int NUM_SLOTS = 4,
   localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [7:0]       wr_data,
   input logic             tx_en,
   input logic             rx_req,
   input logic             rx_grant,
   input logic             tx_valid,
   input logic [7:0]       alloc_result,
   input logic [7:0]       done_head,
   input logic [7:0]       rx_head,
   input logic [7:0]       int_status,
   input logic [7:0]       int_mask,
   input logic             irq,
   input logic [CNT_W-1:0] used_count
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(NUM_SLOTS);

   logic alloc_cmd;
   assign alloc_cmd = wr_en && wr_sel == 2'd0 && wr_data[7:5] == 3'd1;

   a_r3_alloc_full: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_cmd && used_count == CAP) |=> (alloc_result == 8'h80 && !int_status[3]));

   a_r3_alloc_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_cmd && used_count != CAP) |=>
         (alloc_result < 8'(NUM_SLOTS) && int_status[3] && used_count == $past(used_count) + 1'b1));

   a_r1_result_range: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_result == 8'h80 || alloc_result < 8'(NUM_SLOTS));

   a_r12_heads_range: assert property (@(posedge clk) disable iff (!rst_n)
      (done_head == 8'h80 || done_head < 8'(NUM_SLOTS)) && (rx_head == 8'h80 || rx_head < 8'(NUM_SLOTS)));

   a_r11_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_en);

   a_r14_rx_yields: assert property (@(posedge clk) disable iff (!rst_n)
      rx_grant |-> !wr_en);

   a_r14_tx_yields: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (!wr_en && !rx_req));

   a_r5_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && wr_data == 8'h00) |=> (!irq && int_mask == 8'h00));

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data[4]) |=> !int_status[4]);

   a_r13_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
      used_count <= CAP);

endmodule

bind pool_mgr pool_mgr_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/pool_mgr_test.sv
`timescale 1ns/1ps
module pool_mgr_test;

   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd3;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] pkt_num = 2'd0;
   logic       tx_en = 1'b0, auto_release = 1'b0, rx_req = 1'b0, tx_ready = 1'b0;
   logic       rx_grant, tx_valid, irq;
   logic [1:0] rx_slot, tx_slot;
   logic [7:0] alloc_result, done_head, rx_head, int_status, int_mask;
   logic [2:0] used_count, total_slots;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pool_mgr #(.NUM_SLOTS(N)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pkt_num(pkt_num), .tx_en(tx_en), .auto_release(auto_release), .rx_req(rx_req),
      .rx_grant(rx_grant), .rx_slot(rx_slot), .tx_valid(tx_valid), .tx_slot(tx_slot),
      .tx_ready(tx_ready), .alloc_result(alloc_result), .done_head(done_head),
      .rx_head(rx_head), .int_status(int_status), .int_mask(int_mask), .irq(irq),
      .used_count(used_count), .total_slots(total_slots)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one host write, taken at exactly one rising edge; returns on a falling edge
   task automatic host(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   task automatic tx_pulse();
      @(negedge clk);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   task automatic rx_pulse(input logic [1:0] exp_slot, input string tag);
      @(negedge clk);
      rx_req = 1'b1;
      #1;
      check({tag, " grant"}, rx_grant, 1);
      check({tag, " slot"}, rx_slot, exp_slot);
      @(negedge clk);
      rx_req = 1'b0;
   endtask

   task automatic t_reset();
      check("R13 status", int_status, 8'h04);
      check("R13 mask", int_mask, 0);
      check("R13 result", alloc_result, 0);
      check("R12 done head", done_head, 8'h80);
      check("R12 rx head", rx_head, 8'h80);
      check("R13 used", used_count, 0);
      check("R13 total", total_slots, N);
      check("R13 irq", irq, 0);
   endtask

   task automatic t_alloc();
      host(2'd0, 8'h20);
      check("R3 first slot", alloc_result, 0);
      check("R3 alloc bit", int_status, 8'h0C);
      check("R13 used one", used_count, 1);
      host(2'd0, 8'h3F);
      check("R2 low bits ignored", alloc_result, 1);
      host(2'd0, 8'h20);
      host(2'd0, 8'h20);
      check("R1 lowest order", alloc_result, 3);
      check("R13 used full", used_count, 4);
      host(2'd0, 8'h20);
      check("R1 full result", alloc_result, 8'h80);
      check("R3 full clears bit", int_status, 8'h04);
      host(2'd0, 8'h1F);
      check("R2 nop result", alloc_result, 8'h80);
      check("R2 nop used", used_count, 4);
      host(2'd3, 8'hFF);
      check("R2 sel3 status", int_status, 8'h04);
   endtask

   task automatic t_retry();
      pkt_num = 2'd2;
      host(2'd0, 8'hA0);
      check("R4 retry grant", alloc_result, 2);
      check("R4 retry bit", int_status, 8'h0C);
      check("R4 retry used", used_count, 4);
      pkt_num = 2'd1;
      host(2'd0, 8'hA0);
      check("R10 free no retry", alloc_result, 2);
      check("R10 free used", used_count, 3);
      host(2'd0, 8'h40);
      check("R10 pool reset used", used_count, 0);
      check("R10 pool reset result", alloc_result, 0);
      check("R10 pool reset status", int_status, 8'h0C);
   endtask

   task automatic t_irq();
      host(2'd2, 8'h08);
      check("R5 mask reg", int_mask, 8'h08);
      check("R5 irq on", irq, 1);
      host(2'd1, 8'hFF);
      check("R7 ack keeps 0/3, R6 resets 2", int_status, 8'h0C);
      host(2'd2, 8'h01);
      check("R5 irq off", irq, 0);
      host(2'd2, 8'h00);
   endtask

   task automatic t_rx();
      rx_pulse(2'd0, "R8 rx first");
      check("R8 rx head", rx_head, 0);
      check("R8 rx bit", int_status[0], 1);
      rx_pulse(2'd1, "R8 rx second");
      check("R8 rx head kept", rx_head, 0);
      check("R8 used", used_count, 2);
      @(negedge clk);
      rx_req = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h00;
      #1;
      check("R14 rx blocked", rx_grant, 0);
      @(negedge clk);
      rx_req = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
      check("R14 rx blocked used", used_count, 2);
      host(2'd0, 8'h60);
      check("R9 drop head", rx_head, 1);
      check("R9 bit kept", int_status[0], 1);
      check("R9 drop no free", used_count, 2);
      host(2'd0, 8'h80);
      check("R9 free head", rx_head, 8'h80);
      check("R9 bit cleared", int_status[0], 0);
      check("R9 freed used", used_count, 1);
      host(2'd0, 8'h40);
   endtask

   task automatic t_tx();
      host(2'd0, 8'h20);
      pkt_num = 2'd0;
      host(2'd0, 8'hC0);
      check("R11 gated off", tx_valid, 0);
      check("R6 sticky empty", int_status[2], 1);
      host(2'd1, 8'h04);
      check("R6 empty cleared", int_status[2], 0);
      host(2'd0, 8'h20);
      pkt_num = 2'd1;
      host(2'd0, 8'hC0);
      tx_en = 1'b1;
      #1;
      check("R11 valid", tx_valid, 1);
      check("R11 first slot", tx_slot, 0);
      tx_pulse();
      check("R11 done head", done_head, 0);
      check("R6 done bit", int_status[1], 1);
      check("R6 not empty", int_status[2], 0);
      check("R11 order", tx_slot, 1);
      tx_pulse();
      check("R6 empty again", int_status[2], 1);
      check("R11 drained", tx_valid, 0);
      check("R11 kept slots", used_count, 2);
      host(2'd1, 8'h02);
      check("R7 pop done", done_head, 1);
      check("R7 bit reset", int_status[1], 1);
      host(2'd1, 8'h02);
      check("R7 done empty", done_head, 8'h80);
      check("R7 bit clear", int_status[1], 0);
      host(2'd0, 8'h20);
      host(2'd0, 8'h20);
      host(2'd0, 8'h20);
      check("R1 pending", alloc_result, 8'h80);
      pkt_num = 2'd0;
      host(2'd0, 8'hC0);
      check("R11 requeued", tx_slot, 0);
      @(negedge clk);
      rx_req = 1'b1;
      #1;
      check("R14 tx blocked", tx_valid, 0);
      check("R8 full no grant", rx_grant, 0);
      @(negedge clk);
      rx_req = 1'b0;
      auto_release = 1'b1;
      tx_pulse();
      check("R4 auto retry", alloc_result, 0);
      check("R4 auto bit", int_status[3], 1);
      check("R11 auto used", used_count, 4);
      check("R11 auto no done", done_head, 8'h80);
      auto_release = 1'b0;
      pkt_num = 2'd1;
      host(2'd0, 8'hC0);
      tx_pulse();
      check("R11 done push", done_head, 1);
      tx_en = 1'b0;
      pkt_num = 2'd2;
      host(2'd0, 8'hC0);
      host(2'd0, 8'hE0);
      check("R10 flush done", done_head, 8'h80);
      tx_en = 1'b1;
      #1;
      check("R10 flush tx", tx_valid, 0);
      tx_en = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alloc();
      t_retry();
      t_irq();
      t_rx();
      t_tx();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule